// File: doc/BRIEF.md
# Interrupt Wait and Expectation Monitor

This block watches one interrupt line coming from a device under test and offers two independent services. The first is a bounded wait: a start strobe arms a cycle counter that advances on every rising clock edge while the interrupt stays low. The wait ends with a one-cycle completion pulse as soon as the interrupt is seen high. If the count reaches a programmable limit first, a sticky timeout flag is raised instead. The limit resets to 60000 cycles and can be reloaded at any time.

The second service classifies interrupt pulses. The line is assumed to rise just after a rising clock edge and to stay high for exactly one clock. It is therefore sampled on the falling clock edge, in the middle of the pulse. Each sampled pulse is reported as expected or unexpected, depending on a software-written expect flag. Writing zero to the flag clears it; any other value sets it.

The block is meant for verification environments and self-test wrappers. In both, a controller needs a hardware-enforced bound on how long an interrupt may take, and a record of any interrupt that arrives when none was announced.

Top module: `irq_wait_monitor`

## Requirements
- R1: After reset, `wait_busy_o`, `wait_done_o`, `wait_timeout_o`, `hit_expected_o` and `hit_unexpected_o` are 0, the expect flag is clear and the wait limit is 60000 cycles.
- R2: A rising edge with `limit_load_i` high stores `limit_val_i` as the new wait limit, used by every later count comparison.
- R3: A rising edge with `wait_start_i` high sets `wait_busy_o`, clears the counter to zero and clears `wait_timeout_o`.
- R4: While busy, a rising edge that sees `irq_i` high ends the wait: `wait_busy_o` falls and `wait_done_o` is high for exactly that one cycle. `irq_i` has no effect on the wait engine when it is idle.
- R5: While busy, each rising edge with `irq_i` low adds one to the counter. With limit L, the L-th such edge after the start edge sets `wait_timeout_o` and clears `wait_busy_o` without a done pulse. An interrupt seen on that same edge wins and gives done instead.
- R6: `wait_timeout_o` stays high until the next start edge or reset, whatever `irq_i` does.
- R7: A start edge while a wait is already busy restarts the count from zero, so a timeout needs L further low edges.
- R8: `irq_i` is sampled on the falling clock edge. The resulting hit output is valid from that falling edge to the next one.
- R9: A sampled high `irq_i` drives `hit_expected_o` if the expect flag is set, and `hit_unexpected_o` if it is clear. The two are never high together, and both are low after a falling edge that samples `irq_i` low.
- R10: A rising edge with `expect_we_i` high sets the expect flag if `expect_val_i` is nonzero and clears it if it is zero. The new value first affects the falling edge after that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Monitored interrupt line |
| wait_start_i | input | 1 | Start or restart a wait |
| limit_load_i | input | 1 | Load a new wait limit |
| limit_val_i | input | LIMIT_W | Wait limit value in cycles |
| expect_we_i | input | 1 | Write the expect flag |
| expect_val_i | input | EXP_W | Expect value, nonzero sets the flag |
| wait_busy_o | output | 1 | Wait in progress |
| wait_done_o | output | 1 | One-cycle pulse: interrupt arrived during a wait |
| wait_timeout_o | output | 1 | Sticky: limit reached before the interrupt |
| hit_expected_o | output | 1 | Sampled interrupt while the flag was set |
| hit_unexpected_o | output | 1 | Sampled interrupt while the flag was clear |

## Verification
The checker assumes that every input changes only between clock edges. In particular, `irq_i` must hold one value across each falling edge and the rising edge that follows it. Under that assumption, the hit outputs seen at a rising edge match `irq_i` at that edge. The bench drives every input one nanosecond after a rising edge and holds it for a full period. This keeps each interrupt pulse whole around both edges. Wait limits are loaded only as nonzero values, and only while no wait is busy.

// File: rtl/irq_mon_pkg.sv
package irq_mon_pkg;
  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WAIT = 1'b1
  } wait_state_e;

  localparam int unsigned DEF_LIMIT_W = 16;
  localparam int unsigned DEF_LIMIT   = 60000;
endpackage

// File: rtl/irq_limit_reg.sv
module irq_limit_reg #(
  parameter int unsigned LIMIT_W       = 16,
  parameter int unsigned DEFAULT_LIMIT = 60000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LIMIT_W-1:0] val_i,
  output logic [LIMIT_W-1:0] limit_o
);
  localparam logic [LIMIT_W-1:0] RST_VAL = LIMIT_W'(DEFAULT_LIMIT);

  logic [LIMIT_W-1:0] limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     limit_q <= RST_VAL;
    else if (load_i) limit_q <= val_i;
  end

  assign limit_o = limit_q;
endmodule

// File: rtl/irq_wait_ctrl.sv
module irq_wait_ctrl
  import irq_mon_pkg::*;
#(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               irq_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  wait_state_e        state_q, state_d;
  logic [LIMIT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic               done_q, done_d;
  logic               tmo_q, tmo_d;

  assign cnt_inc = cnt_q + LIMIT_W'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    tmo_d   = tmo_q;
    if (start_i) begin
      // a start also restarts a wait already in progress
      state_d = WS_WAIT;
      cnt_d   = '0;
      tmo_d   = 1'b0;
    end else if (state_q == WS_WAIT) begin
      if (irq_i) begin
        state_d = WS_IDLE;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_inc;
        if (cnt_inc == limit_i) begin
          state_d = WS_IDLE;
          tmo_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign busy_o    = (state_q == WS_WAIT);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/irq_expect_flag.sv
module irq_expect_flag #(
  parameter int unsigned EXP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [EXP_W-1:0] val_i,
  output logic             flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_q <= 1'b0;
    else if (we_i) flag_q <= |val_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pulse_classifier.sv
module irq_pulse_classifier (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic expect_i,
  output logic hit_exp_o,
  output logic hit_unexp_o
);
  logic hit_exp_q, hit_unexp_q;

  // mid-pulse sampling: the line rises after a rising edge and lasts one clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_exp_q   <= 1'b0;
      hit_unexp_q <= 1'b0;
    end else begin
      hit_exp_q   <= irq_i & expect_i;
      hit_unexp_q <= irq_i & ~expect_i;
    end
  end

  assign hit_exp_o   = hit_exp_q;
  assign hit_unexp_o = hit_unexp_q;
endmodule

// File: rtl/irq_wait_monitor.sv
module irq_wait_monitor #(
  parameter int unsigned LIMIT_W       = irq_mon_pkg::DEF_LIMIT_W,
  parameter int unsigned DEFAULT_LIMIT = irq_mon_pkg::DEF_LIMIT,
  parameter int unsigned EXP_W         = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_i,
  input  logic               wait_start_i,
  input  logic               limit_load_i,
  input  logic [LIMIT_W-1:0] limit_val_i,
  input  logic               expect_we_i,
  input  logic [EXP_W-1:0]   expect_val_i,
  output logic               wait_busy_o,
  output logic               wait_done_o,
  output logic               wait_timeout_o,
  output logic               hit_expected_o,
  output logic               hit_unexpected_o
);
  logic [LIMIT_W-1:0] limit;
  logic               expect_flag;

  irq_limit_reg #(
    .LIMIT_W      (LIMIT_W),
    .DEFAULT_LIMIT(DEFAULT_LIMIT)
  ) u_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (limit_load_i),
    .val_i  (limit_val_i),
    .limit_o(limit)
  );

  irq_wait_ctrl #(
    .LIMIT_W(LIMIT_W)
  ) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wait_start_i),
    .irq_i    (irq_i),
    .limit_i  (limit),
    .busy_o   (wait_busy_o),
    .done_o   (wait_done_o),
    .timeout_o(wait_timeout_o)
  );

  irq_expect_flag #(
    .EXP_W(EXP_W)
  ) u_expect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (expect_we_i),
    .val_i (expect_val_i),
    .flag_o(expect_flag)
  );

  irq_pulse_classifier u_class (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .expect_i   (expect_flag),
    .hit_exp_o  (hit_expected_o),
    .hit_unexp_o(hit_unexpected_o)
  );
endmodule

// File: rtl/irq_wait_monitor_chk.sv
module irq_wait_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_i,
  input logic wait_start_i,
  input logic wait_busy_o,
  input logic wait_done_o,
  input logic wait_timeout_o,
  input logic hit_expected_o,
  input logic hit_unexpected_o
);
  assert_start_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_start_i |=> (wait_busy_o && !wait_timeout_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |=> !wait_done_o);

  assert_done_ends_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |-> !wait_busy_o);

  assert_idle_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_busy_o && !wait_start_i) |=> (!wait_busy_o && !wait_done_o));

  assert_timeout_no_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wait_done_o && wait_timeout_o));

  assert_timeout_from_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_timeout_o) |-> ($past(wait_busy_o) && !wait_busy_o));

  assert_timeout_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_timeout_o && !wait_start_i) |=> wait_timeout_o);

  assert_restart_keeps_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_busy_o && wait_start_i) |=> (wait_busy_o && !wait_done_o));

  assert_hit_follows_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_expected_o || hit_unexpected_o) == irq_i);

  assert_hits_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_expected_o && hit_unexpected_o));
endmodule

bind irq_wait_monitor irq_wait_monitor_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .irq_i           (irq_i),
  .wait_start_i    (wait_start_i),
  .wait_busy_o     (wait_busy_o),
  .wait_done_o     (wait_done_o),
  .wait_timeout_o  (wait_timeout_o),
  .hit_expected_o  (hit_expected_o),
  .hit_unexpected_o(hit_unexpected_o)
);

// File: tb/irq_wait_monitor_tb_top.sv
`timescale 1ns/1ps
module irq_wait_monitor_tb_top;
  localparam int LW = 16;
  localparam int EW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          irq_i = 1'b0;
  logic          wait_start_i = 1'b0;
  logic          limit_load_i = 1'b0;
  logic [LW-1:0] limit_val_i = '0;
  logic          expect_we_i = 1'b0;
  logic [EW-1:0] expect_val_i = '0;
  logic          wait_busy_o, wait_done_o, wait_timeout_o;
  logic          hit_expected_o, hit_unexpected_o;

  always #2 clk_i = ~clk_i;

  irq_wait_monitor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .wait_start_i(wait_start_i), .limit_load_i(limit_load_i),
    .limit_val_i(limit_val_i), .expect_we_i(expect_we_i),
    .expect_val_i(expect_val_i), .wait_busy_o(wait_busy_o),
    .wait_done_o(wait_done_o), .wait_timeout_o(wait_timeout_o),
    .hit_expected_o(hit_expected_o), .hit_unexpected_o(hit_unexpected_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_limit = 60000;
  int m_cnt   = 0;
  bit m_busy = 0, m_done = 0, m_tmo = 0, m_flag = 0, m_hexp = 0, m_hun = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    // falling edge inside the cycle uses the flag before this cycle's write
    m_hexp = irq_i && m_flag;
    m_hun  = irq_i && !m_flag;
    m_done = 0;
    if (wait_start_i) begin
      m_busy = 1; m_cnt = 0; m_tmo = 0;
    end else if (m_busy) begin
      if (irq_i) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_cnt++;
        if (m_cnt == m_limit) begin m_busy = 0; m_tmo = 1; end
      end
    end
    if (limit_load_i) m_limit = int'(limit_val_i);
    if (expect_we_i)  m_flag = (expect_val_i != 0);
  endtask

  task automatic compare_all();
    chk("R3 busy",    int'(wait_busy_o),      int'(m_busy));
    chk("R4 done",    int'(wait_done_o),      int'(m_done));
    chk("R5 timeout", int'(wait_timeout_o),   int'(m_tmo));
    chk("R9 hit_exp", int'(hit_expected_o),   int'(m_hexp));
    chk("R9 hit_une", int'(hit_unexpected_o), int'(m_hun));
  endtask

  // inputs are already driven at posedge+1; advance one clock and compare
  task automatic tick();
    @(posedge clk_i);
    model_step();
    #1;
    compare_all();
    wait_start_i = 0; limit_load_i = 0; expect_we_i = 0; irq_i = 0;
  endtask

  task automatic run_to_timeout(output int n);
    n = 0;
    while (!wait_timeout_o && n < 70000) begin
      tick();
      n++;
    end
  endtask

  int n;

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset busy",    int'(wait_busy_o), 0);
    chk("R1 reset timeout", int'(wait_timeout_o), 0);
    chk("R1 reset hits",    int'(hit_expected_o | hit_unexpected_o), 0);
    rst_ni = 1;
    tick(); tick();

    // R1: default limit of 60000
    wait_start_i = 1; tick();
    chk("R3 busy after start", int'(wait_busy_o), 1);
    run_to_timeout(n);
    chk("R1 default limit cycles", n, 60000);
    chk("R5 busy cleared by timeout", int'(wait_busy_o), 0);

    // R6: sticky timeout, irq while idle has no wait effect
    irq_i = 1; tick();
    chk("R4 idle irq no done", int'(wait_done_o), 0);
    chk("R6 timeout held", int'(wait_timeout_o), 1);
    repeat (5) tick();
    chk("R6 timeout still held", int'(wait_timeout_o), 1);

    // R2: load a short limit
    limit_load_i = 1; limit_val_i = 16'd10; tick();
    wait_start_i = 1; tick();
    chk("R3 start clears timeout", int'(wait_timeout_o), 0);
    run_to_timeout(n);
    chk("R2 loaded limit cycles", n, 10);

    // R4: interrupt ends the wait with a single done pulse
    wait_start_i = 1; tick();
    repeat (3) tick();
    irq_i = 1; tick();
    chk("R4 done pulse", int'(wait_done_o), 1);
    chk("R4 busy dropped", int'(wait_busy_o), 0);
    tick();
    chk("R4 done one cycle", int'(wait_done_o), 0);

    // R5: interrupt on the limit edge beats the timeout
    wait_start_i = 1; tick();
    repeat (9) tick();
    chk("R5 still busy before limit", int'(wait_busy_o), 1);
    irq_i = 1; tick();
    chk("R5 irq at limit gives done", int'(wait_done_o), 1);
    chk("R5 irq at limit no timeout", int'(wait_timeout_o), 0);

    // R7: restart mid-wait
    wait_start_i = 1; tick();
    repeat (5) tick();
    wait_start_i = 1; tick();
    run_to_timeout(n);
    chk("R7 restart full count", n, 10);

    // R10 + R9 + R8: expect flag and classification
    expect_we_i = 1; expect_val_i = 8'h40; tick();
    irq_i = 1; tick();
    chk("R9 expected hit", int'(hit_expected_o), 1);
    chk("R9 no unexpected", int'(hit_unexpected_o), 0);
    tick();
    chk("R8 hit cleared after low sample", int'(hit_expected_o), 0);
    expect_we_i = 1; expect_val_i = 8'h00; tick();
    irq_i = 1; tick();
    chk("R10 zero clears flag", int'(hit_unexpected_o), 1);
    // write and pulse in the same cycle: old flag still governs
    expect_we_i = 1; expect_val_i = 8'h01; irq_i = 1; tick();
    chk("R10 write not yet visible", int'(hit_unexpected_o), 1);
    irq_i = 1; tick();
    chk("R10 flag set next pulse", int'(hit_expected_o), 1);
    irq_i = 1; tick();
    chk("R8 back-to-back pulse", int'(hit_expected_o), 1);
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule